// File: doc/BRIEF.md
# Cascadable Parallel-Load Shift Register

This block is an eight-stage shift register (width set by a parameter) that works in two modes. While its active-low load control is asserted, the stages copy the parallel data inputs straight away, without waiting for a clock edge. While the load control is released, every rising edge of the internal clock moves each stage's bit one place toward the last stage, and the first stage takes the serial input. The last stage drives a serial output and, next to it, the inverse of that bit.

The internal clock is the OR of two pins, the clock and an active-low enable. Holding the enable high keeps the internal clock high, so no further rising edges reach the stages. Because the OR treats both pins the same way, either pin can act as the clock while the other acts as the enable. The pin that acts as the enable should only go high while the other pin is already high. Otherwise its own rising edge would count as a shift.

To build a longer converter, connect the serial output of one copy to the serial input of the next. All copies share the clock, the enable and the load control. After one load, the chain streams out every stored bit, starting with the copy nearest the output.

Top module: `piso_shift_reg`

## Requirements
- R1: While load_n is low, the stages copy pdata with no clock edge needed, and ser_out shows pdata[7] at once. pdata must stay stable for as long as load_n is low.
- R2: While load_n is high, each rising edge of the internal clock moves stage i into stage i+1, and stage 0 takes ser_in. A bit applied at ser_in appears on ser_out after exactly eight edges.
- R3: While ce_n is high, edges on clk have no effect and ser_out holds its value. When ce_n goes low again while clk is low, shifting resumes on the next rising edge of clk.
- R4: clk and ce_n can swap roles. With clk held low, each rising edge of ce_n shifts the register by one place.
- R5: ser_out is the last stage. Right after a load it shows pdata[7], and each following edge shows the next lower bit, down to pdata[0] after seven edges.
- R6: ser_out_n is always the inverse of ser_out.
- R7: A low load_n overrides clock edges, which leave the loaded value in place. After load_n rises, the loaded value stays put until the next qualifying edge.
- R8: When two copies are chained (the first copy's ser_out drives the second copy's ser_in), one load followed by clocking streams the second copy's byte and then the first copy's byte, each from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock pin, ORed with ce_n to form the internal clock |
| ce_n | input | 1 | Active-low clock enable, interchangeable with clk |
| load_n | input | 1 | Active-low asynchronous parallel load |
| pdata | input | WIDTH | Parallel data, bit WIDTH-1 goes to the last stage |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Last-stage bit |
| ser_out_n | output | 1 | Inverse of the last-stage bit |

## Verification
The only state that can be observed is the last stage, so a wrong bit in stage k stays hidden until 7-k further edges have moved it to ser_out. Each stream test therefore clocks a full byte and compares every bit. A fault in the enable gating or the load priority shows up within one clock period, as a shift that should not have happened or a missing shift. A fault in the chaining shows up only in the second half of the sixteen-bit stream from the cascade test.

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             ce_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] pdata,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_out_n
);

  logic             gclk;
  logic [WIDTH-1:0] stages;

  assign gclk = clk | ce_n;

  always_ff @(posedge gclk or negedge load_n) begin
    if (!load_n) stages <= pdata;
    else         stages <= {stages[WIDTH-2:0], ser_in};
  end

  assign ser_out   = load_n ? stages[WIDTH-1] : pdata[WIDTH-1];
  assign ser_out_n = ~ser_out;

  // history of the previous internal-clock edge, voided by any load
  logic             hist_ok;
  logic [WIDTH-1:0] hist_q;
  logic             hist_ds;
  logic             seen_load;

  always_ff @(posedge gclk or negedge load_n) begin
    if (!load_n) begin
      hist_ok <= 1'b0;
    end else begin
      hist_ok <= 1'b1;
      hist_q  <= stages;
      hist_ds <= ser_in;
    end
  end

  always_ff @(negedge load_n) seen_load <= 1'b1;

  p_shift_r2: assert property (@(posedge gclk) disable iff (!load_n)
    hist_ok |-> stages == {hist_q[WIDTH-2:0], hist_ds});

  p_sout_r5: assert property (@(posedge gclk) disable iff (!load_n)
    hist_ok |-> ser_out == hist_q[WIDTH-2]);

  p_comp_r6: assert property (@(posedge gclk) disable iff (!load_n)
    hist_ok |-> ser_out_n == ~hist_q[WIDTH-2]);

  always @(posedge load_n) begin
    if (seen_load === 1'b1) begin
      p_load_r7: assert (stages == pdata);
    end
  end

endmodule

// File: tb/piso_shift_reg_tb.sv
module piso_shift_reg_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic ce_n = 1'b0;
  logic load_n = 1'b0;
  logic [W-1:0] pdata = '0;
  logic [W-1:0] pdata2 = '0;
  logic ser_in = 1'b0;
  logic ser_out, ser_out_n, sout2, sout2_n;
  int errs = 0;
  int checks = 0;
  logic done = 1'b0;

  always begin
    #4;
    if (clk_run) clk = ~clk;
  end

  piso_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .ce_n(ce_n), .load_n(load_n), .pdata(pdata),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_n(ser_out_n));

  piso_shift_reg #(.WIDTH(W)) u_dut2 (
    .clk(clk), .ce_n(ce_n), .load_n(load_n), .pdata(pdata2),
    .ser_in(ser_out), .ser_out(sout2), .ser_out_n(sout2_n));

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // load b with the clock running; hold load across one rising edge
  task automatic do_load(input logic [W-1:0] b, input logic [W-1:0] b2);
    @(negedge clk); #1;
    pdata = b; pdata2 = b2; ser_in = 1'b0; load_n = 1'b0;
    #1 chk("R1", ser_out, b[W-1]);
    chk("R6", ser_out_n, ~b[W-1]);
    @(negedge clk); #1;
    chk("R7", ser_out, b[W-1]);
    load_n = 1'b1;
    #1 chk("R7", ser_out, b[W-1]);
  endtask

  task automatic t_stream(input logic [W-1:0] b);
    do_load(b, '0);
    for (int k = W - 2; k >= 0; k--) begin
      @(negedge clk); #1;
      chk("R5", ser_out, b[k]);
      chk("R6", ser_out_n, ~b[k]);
    end
  endtask

  task automatic t_serial_in;
    do_load('0, '0);
    ser_in = 1'b1;
    for (int n = 1; n <= 9; n++) begin
      @(negedge clk); #1;
      ser_in = 1'b0;
      chk("R2", ser_out, (n == 8));
    end
  endtask

  task automatic t_enable(input logic [W-1:0] b);
    do_load(b, '0);
    @(posedge clk); #1;           // this edge shifts once: b[6] now out
    ce_n = 1'b1;                  // raised while clk high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R3", ser_out, b[W-2]);
    end
    ce_n = 1'b0;                  // lowered while clk low
    @(negedge clk); #1;
    chk("R3", ser_out, b[W-3]);
  endtask

  task automatic t_swap(input logic [W-1:0] b);
    @(negedge clk); #1;
    clk_run = 1'b0;               // clk parked low
    #8;
    pdata = b; load_n = 1'b0;
    #2 chk("R1", ser_out, b[W-1]);
    load_n = 1'b1;
    #2 chk("R1", ser_out, b[W-1]);
    for (int k = W - 2; k >= W - 4; k--) begin
      #2 ce_n = 1'b1;
      #2 ce_n = 1'b0;
      #2 chk("R4", ser_out, b[k]);
    end
    #2 clk_run = 1'b1;
  endtask

  task automatic t_override(input logic [W-1:0] b);
    do_load(8'h00, '0);
    @(negedge clk); #1;
    pdata = b; load_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R7", ser_out, b[W-1]);
    end
    load_n = 1'b1;
    #1 chk("R7", ser_out, b[W-1]);
    @(negedge clk); #1;
    chk("R7", ser_out, b[W-2]);
  endtask

  task automatic t_cascade(input logic [W-1:0] b1, input logic [W-1:0] b2);
    logic [2*W-1:0] stream;
    stream = {b2, b1};
    do_load(b1, b2);
    chk("R8", sout2, stream[2*W-1]);
    for (int n = 1; n < 2 * W; n++) begin
      @(negedge clk); #1;
      chk("R8", sout2, stream[2*W-1-n]);
    end
  endtask

  initial begin
    #3;
    chk("R1", ser_out, 1'b0);     // loaded with zero at time 0
    chk("R6", ser_out_n, 1'b1);
    t_stream(8'hA5);
    t_stream(8'h3C);
    t_serial_in();
    t_enable(8'hB4);
    t_swap(8'h9A);
    t_override(8'hE1);
    t_cascade(8'h96, 8'h3C);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule